// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a binary sample code into the switch controls of a segmented current-steering converter. The code is registered on the rising clock edge and split into two fields. The upper field becomes a thermometer code that drives a row of equal-weight major segments. The lower field drives a short row of binary-weighted switches directly. Every switch has a true line, which steers its current to the A output, and a complement line, which steers it to the B output.

A second register stage follows the decoder. It updates all switch lines on the same edge, so the analog array sees one clean transition per sample. An active-high sleep input forces every line, both A and B, to zero, which turns all sources off. A weighted-sum output gives the A-side weight in LSB units, so that the switch pattern can be checked against the code that produced it.

With the default parameters the block has a 10-bit code, 5 upper bits that drive 31 segments, and 5 lower bits. Each segment is worth 32 LSB.

Top module: `segdac_decoder`

## Requirements
- R1: A code present at the input before a rising edge is captured on that edge. The switch lines and the sum output show it after the following rising edge, which gives a latency of two edges.
- R2: Segment line `seg_a[k]` (k = 0 to 30) is 1 exactly when the upper five-bit value of the code is greater than k. The pattern is always a contiguous run of ones starting at bit 0.
- R3: `lsb_a[i]` (i = 0 to 4) equals bit i of the code, with weight 2^i LSB.
- R4: When the code steps up by one from a value whose lower five bits are all ones, every `lsb_a` line goes to 0 and exactly one more segment line turns on.
- R5: When the block is not sleeping, `seg_b` is the bitwise inverse of `seg_a` and `lsb_b` is the bitwise inverse of `lsb_a`. The A weight plus the B weight always equals 1023 LSB. A segment counts as 32 LSB.
- R6: When sleep is high at a rising edge, all A and B lines are 0 and the sum is 0 after that edge.
- R7: The sum output equals 32 × (number of active A segments) + (value of `lsb_a`). Outside sleep and reset, this equals the code captured two edges earlier.
- R8: When rst_n is low at a rising edge, both stages are cleared to code zero: `seg_a` = 0, `lsb_a` = 0, `seg_b` and `lsb_b` all ones, sum = 0. Reset takes priority over sleep.
- R9: The capture stage keeps loading during sleep. After sleep falls, the first switch pattern shows the code captured on the last sleeping edge.
- R10: Code 1023 turns on every A line and code 0 turns on every B line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Active-high power-down, forces all switch lines off |
| code_in | input | 10 | Sample code |
| seg_a | output | 31 | Major segment switches toward output A (thermometer) |
| seg_b | output | 31 | Major segment switches toward output B |
| lsb_a | output | 5 | Binary-weighted switches toward output A |
| lsb_b | output | 5 | Binary-weighted switches toward output B |
| sum_a | output | 10 | A-side weight in LSB units |

## Verification
Two events can meet on a single edge: sleep forcing the output stage off, and a new code being captured into the first stage. The bench holds sleep high while it drives fresh codes. It checks that the lines stay all-off during sleep. After sleep drops, it checks that the first pattern decodes the code captured on the last sleeping edge, and the next pattern decodes the code applied on the waking edge. Reset and sleep are also asserted together, to show that reset wins. Exhaustive and scrambled sweeps over all 1024 codes compare every output two edges after each code is applied.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

   localparam int unsigned DEF_CODE_W = 10;
   localparam int unsigned DEF_MSB_W  = 5;

   // number of equal-weight segments for a given upper-field width
   function automatic int unsigned seg_count(input int unsigned msb_w);
      return (1 << msb_w) - 1;
   endfunction

endpackage

// File: rtl/segdac_inreg.sv
module segdac_inreg #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
   parameter int unsigned MSB_W = 5,
   parameter int unsigned SEG_N = 31
) (
   input  logic [MSB_W-1:0] upper,
   output logic [SEG_N-1:0] therm
);

   if (SEG_N != (1 << MSB_W) - 1) begin : g_bad_cfg
      $error("segdac_thermo: SEG_N must equal 2**MSB_W-1");
   end

   // one magnitude comparator per segment keeps the code monotonic
   for (genvar k = 0; k < SEG_N; k++) begin : g_seg
      assign therm[k] = (upper > MSB_W'(k));
   end

endmodule

// File: rtl/segdac_switch_reg.sv
module segdac_switch_reg #(
   parameter int unsigned SEG_N = 31,
   parameter int unsigned LSB_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic [SEG_N-1:0] therm_d,
   input  logic [LSB_W-1:0] lsb_d,
   output logic [SEG_N-1:0] seg_a,
   output logic [SEG_N-1:0] seg_b,
   output logic [LSB_W-1:0] lsb_a,
   output logic [LSB_W-1:0] lsb_b
);

   // both polarities get their own flops so every line moves on one edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_a <= '0;
         lsb_a <= '0;
         seg_b <= '1;
         lsb_b <= '1;
      end else if (sleep) begin
         seg_a <= '0;
         lsb_a <= '0;
         seg_b <= '0;
         lsb_b <= '0;
      end else begin
         seg_a <= therm_d;
         lsb_a <= lsb_d;
         seg_b <= ~therm_d;
         lsb_b <= ~lsb_d;
      end
   end

endmodule

// File: rtl/segdac_wsum.sv
module segdac_wsum #(
   parameter int unsigned SEG_N  = 31,
   parameter int unsigned LSB_W  = 5,
   parameter int unsigned CODE_W = 10
) (
   input  logic [SEG_N-1:0]  seg,
   input  logic [LSB_W-1:0]  lsb,
   output logic [CODE_W-1:0] total
);

   localparam logic [CODE_W-1:0] SEG_WEIGHT = CODE_W'(1) << LSB_W;

   always_comb begin
      total = CODE_W'(lsb);
      for (int k = 0; k < int'(SEG_N); k++) begin
         if (seg[k]) total = total + SEG_WEIGHT;
      end
   end

endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder #(
   parameter int unsigned CODE_W = segdac_pkg::DEF_CODE_W,
   parameter int unsigned MSB_W  = segdac_pkg::DEF_MSB_W
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    sleep,
   input  logic [CODE_W-1:0]                       code_in,
   output logic [segdac_pkg::seg_count(MSB_W)-1:0] seg_a,
   output logic [segdac_pkg::seg_count(MSB_W)-1:0] seg_b,
   output logic [CODE_W-MSB_W-1:0]                 lsb_a,
   output logic [CODE_W-MSB_W-1:0]                 lsb_b,
   output logic [CODE_W-1:0]                       sum_a
);

   localparam int unsigned LSB_W = CODE_W - MSB_W;
   localparam int unsigned SEG_N = segdac_pkg::seg_count(MSB_W);

   if (MSB_W < 1 || MSB_W > 8) begin : g_bad_msb
      $error("segdac_decoder: MSB_W must be 1..8");
   end
   if (CODE_W <= MSB_W) begin : g_bad_code
      $error("segdac_decoder: CODE_W must exceed MSB_W");
   end

   logic [CODE_W-1:0] code_q;
   logic [SEG_N-1:0]  therm;

   segdac_inreg #(.W(CODE_W)) u_inreg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (code_in),
      .q     (code_q)
   );

   segdac_thermo #(.MSB_W(MSB_W), .SEG_N(SEG_N)) u_thermo (
      .upper (code_q[CODE_W-1:LSB_W]),
      .therm (therm)
   );

   segdac_switch_reg #(.SEG_N(SEG_N), .LSB_W(LSB_W)) u_swreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .therm_d (therm),
      .lsb_d   (code_q[LSB_W-1:0]),
      .seg_a   (seg_a),
      .seg_b   (seg_b),
      .lsb_a   (lsb_a),
      .lsb_b   (lsb_b)
   );

   segdac_wsum #(.SEG_N(SEG_N), .LSB_W(LSB_W), .CODE_W(CODE_W)) u_wsum (
      .seg   (seg_a),
      .lsb   (lsb_a),
      .total (sum_a)
   );

endmodule

// File: rtl/segdac_decoder_chk.sv
module segdac_decoder_chk #(
   parameter int unsigned CODE_W = 10,
   parameter int unsigned MSB_W  = 5
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    sleep,
   input logic [CODE_W-1:0]                       code_in,
   input logic [segdac_pkg::seg_count(MSB_W)-1:0] seg_a,
   input logic [segdac_pkg::seg_count(MSB_W)-1:0] seg_b,
   input logic [CODE_W-MSB_W-1:0]                 lsb_a,
   input logic [CODE_W-MSB_W-1:0]                 lsb_b,
   input logic [CODE_W-1:0]                       sum_a
);

   localparam int unsigned LSB_W = CODE_W - MSB_W;
   localparam int unsigned SEG_N = segdac_pkg::seg_count(MSB_W);

   logic [CODE_W-1:0] weight_b;
   assign weight_b = (CODE_W'($countones(seg_b)) << LSB_W) + CODE_W'(lsb_b);

   assert_thermo_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((SEG_N'(seg_a + SEG_N'(1))) & seg_a) == '0);

   assert_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sleep)) |-> (seg_b == ~seg_a && lsb_b == ~lsb_a));

   assert_weight_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sleep)) |-> (CODE_W'(sum_a + weight_b) == '1));

   assert_sleep_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sleep)) |->
         (seg_a == '0 && seg_b == '0 && lsb_a == '0 && lsb_b == '0 && sum_a == '0));

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(rst_n) && !$past(sleep)) |-> (sum_a == $past(code_in, 2)));

   assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (seg_a == '0 && lsb_a == '0 && seg_b == '1 && lsb_b == '1));

   assert_boundary_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sleep) && $past(lsb_a) == '1 && lsb_a == '0
       && !$stable(seg_a) && $past(seg_a) != '1)
      |-> ($countones(seg_a) == $countones($past(seg_a)) + 1));

endmodule

bind segdac_decoder segdac_decoder_chk #(.CODE_W(CODE_W), .MSB_W(MSB_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sleep   (sleep),
   .code_in (code_in),
   .seg_a   (seg_a),
   .seg_b   (seg_b),
   .lsb_a   (lsb_a),
   .lsb_b   (lsb_b),
   .sum_a   (sum_a)
);

// File: tb/segdac_decoder_tb.sv
module segdac_decoder_tb;

   localparam int CODE_W = 10;
   localparam int MSB_W  = 5;
   localparam int LSB_W  = CODE_W - MSB_W;
   localparam int SEG_N  = (1 << MSB_W) - 1;
   localparam int NCODE  = 1 << CODE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sleep = 1'b0;
   logic [CODE_W-1:0] code_in = '0;
   logic [SEG_N-1:0]  seg_a, seg_b;
   logic [LSB_W-1:0]  lsb_a, lsb_b;
   logic [CODE_W-1:0] sum_a;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   int  prev_cnt = 0;

   always #2 clk = ~clk;

   segdac_decoder #(.CODE_W(CODE_W), .MSB_W(MSB_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .code_in(code_in),
      .seg_a(seg_a), .seg_b(seg_b), .lsb_a(lsb_a), .lsb_b(lsb_b), .sum_a(sum_a)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [SEG_N-1:0] exp_therm(input int up);
      logic [SEG_N-1:0] t;
      for (int k = 0; k < SEG_N; k++) t[k] = (up > k);
      return t;
   endfunction

   function automatic int code_at(input int mode, input int i);
      if (mode == 0) return i;
      return (i * 389 + 17) % NCODE;
   endfunction

   task automatic check_code(input int c);
      logic [SEG_N-1:0] et;
      int bw;
      et = exp_therm(c >> LSB_W);
      chk(seg_a == et, "R2", "seg_a thermometer", seg_a, et);
      chk(lsb_a == LSB_W'(c), "R3", "lsb_a", lsb_a, c % (1 << LSB_W));
      chk(seg_b == ~seg_a && lsb_b == ~lsb_a, "R5", "B lines complement",
          {seg_b, lsb_b}, {~et, ~LSB_W'(c)});
      bw = $countones(seg_b) * (1 << LSB_W) + int'(lsb_b);
      chk(int'(sum_a) + bw == NCODE - 1, "R5", "A+B weight", int'(sum_a) + bw, NCODE - 1);
      chk(int'(sum_a) == c, "R7 R1", "sum two edges later", sum_a, c);
      chk(int'(sum_a) == $countones(seg_a) * (1 << LSB_W) + int'(lsb_a), "R7",
          "sum from lines", sum_a, $countones(seg_a) * (1 << LSB_W) + int'(lsb_a));
      if (c == NCODE - 1)
         chk(seg_a == '1 && lsb_a == '1, "R10", "A full scale", {seg_a, lsb_a}, {SEG_N+LSB_W{1'b1}});
      if (c == 0)
         chk(seg_b == '1 && lsb_b == '1, "R10", "B full scale", {seg_b, lsb_b}, {SEG_N+LSB_W{1'b1}});
   endtask

   task automatic check_reset_state(input string what);
      chk(seg_a == '0 && lsb_a == '0 && sum_a == '0, "R8", {what, " A side"},
          {seg_a, lsb_a, sum_a}, 0);
      chk(seg_b == '1 && lsb_b == '1, "R8", {what, " B side"}, {seg_b, lsb_b},
          {SEG_N+LSB_W{1'b1}});
   endtask

   task automatic run_stream(input int mode);
      for (int i = 0; i < NCODE + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            int c;
            c = code_at(mode, i - 2);
            check_code(c);
            // R4: step up across a lower-field boundary
            if (mode == 0 && c > 0 && (c % (1 << LSB_W)) == 0)
               chk(lsb_a == '0 && $countones(seg_a) == prev_cnt + 1, "R4",
                   "boundary step", $countones(seg_a), prev_cnt + 1);
            prev_cnt = $countones(seg_a);
         end
         if (i < NCODE) code_in = CODE_W'(code_at(mode, i));
      end
   endtask

   initial begin
      // reset with sleep also high: reset wins (R8)
      rst_n = 1'b0; sleep = 1'b1; code_in = 10'h2A5;
      repeat (3) @(negedge clk);
      check_reset_state("during reset");
      rst_n = 1'b1; sleep = 1'b0;
      @(negedge clk);
      check_reset_state("first edge after reset");

      run_stream(0);
      run_stream(1);

      // sleep while new codes arrive (R6, R9)
      @(negedge clk);
      sleep = 1'b1; code_in = 10'd300;
      @(negedge clk);
      chk(seg_a == '0 && seg_b == '0 && lsb_a == '0 && lsb_b == '0 && sum_a == '0,
          "R6", "sleep all off", {seg_a, seg_b, lsb_a, lsb_b}, 0);
      code_in = 10'd555;
      @(negedge clk);
      chk(seg_a == '0 && seg_b == '0 && lsb_a == '0 && lsb_b == '0 && sum_a == '0,
          "R6", "sleep held off", {seg_a, seg_b, lsb_a, lsb_b}, 0);
      sleep = 1'b0; code_in = 10'd77;
      @(negedge clk);
      chk(int'(sum_a) == 555, "R9", "code captured while asleep", sum_a, 555);
      check_code(555);
      @(negedge clk);
      chk(int'(sum_a) == 77, "R9", "code captured on waking edge", sum_a, 77);

      // reset mid-run
      code_in = 10'd700;
      repeat (2) @(negedge clk);
      chk(int'(sum_a) == 700, "R1", "pre-reset code", sum_a, 700);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("stage one cleared");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule